// File: doc/BRIEF.md
# Microprogram Sequencer with Conditional Skip

This block produces the microprogram ROM address for a horizontally microcoded datapath. A program counter steps by one on each clock. The instruction currently being fetched can ask for a conditional skip of the next word, based on the ALU's sign, carry and overflow flags and on a zero test of the ALU result. It can also ask for a jump whose target is the low bits of the ALU result.

A second kind of jump is taken only while an interrupt is pending. The pending state is kept in a latch that is set by a rising edge on the interrupt request. That latch is cleared in the same clock in which the interrupt jump is taken, so the jump takes the interrupt. The block itself holds only the counter and the interrupt latch. The caller presents the instruction word that belongs to the current address, along with the ALU outputs for that word.

Top module: `useq_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, the address becomes 0, the pending interrupt is cleared, and a request level held through reset is not seen as a new edge.
- R2: When no jump is taken and no skip is selected, the address advances by one per clock and wraps from 1023 to 0.
- R3: Bits 15:13 of the instruction select the skip condition: 0 never, 1 negative flag, 2 carry flag, 3 positive, 4 overflow flag clear, 5 overflow clear or negative, 6 overflow clear or positive, 7 always. A satisfied condition advances the address by two.
- R4: Positive means the negative flag is low and the 16-bit ALU result is not zero. A zero result is never positive.
- R5: When bits 25:24 are 01 and bits 11:8 are 1011, the next address is bits 9:0 of the ALU result, with no condition.
- R6: When bits 25:24 are 01 and bits 11:8 are 1001, the jump to bits 9:0 of the ALU result is taken only if an interrupt is pending at that clock. The pending state is then cleared.
- R7: A low-to-high change of `irq_req` between two clocks sets the pending interrupt. It stays set until a taken interrupt jump or a reset. A level held high does not set it again.
- R8: A taken jump overrides any skip in the same word. An interrupt jump that is not taken leaves the skip field in effect.
- R9: An I/O code of 1011 or 1001 in bits 11:8 has no effect on the address unless bits 25:24 are 01.
- R10: If a new request edge arrives in the same clock as a taken interrupt jump, the jump is taken and the interrupt stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 32 | Microinstruction fetched from the current address |
| flag_neg | input | 1 | ALU negative flag |
| flag_carry | input | 1 | ALU carry flag |
| flag_ovf | input | 1 | ALU overflow flag |
| alu_result | input | 16 | ALU result, used as the jump target and for the zero test |
| irq_req | input | 1 | Interrupt request level |
| rom_addr | output | 10 | Microprogram ROM address (program counter) |

## Verification
The collisions that matter are a jump against a skip in the same word, and a taken interrupt jump against a fresh request edge in the same clock. The bench arranges both on purpose. It encodes an unconditional jump and an interrupt jump together with skip-always. It also drops and raises the request so that the edge lands on the clock of a taken interrupt jump. A behavioural model then judges the next address on every clock. After the collision clock, a further interrupt jump shows whether the request stayed pending.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int INSTR_W   = 32;
    localparam int SKIP_HI   = 15;
    localparam int SKIP_LO   = 13;
    localparam int GRP_HI    = 25;
    localparam int GRP_LO    = 24;
    localparam int IOC_HI    = 11;
    localparam int IOC_LO    = 8;

    localparam logic [1:0] IO_GROUP_SEL = 2'b01;
    localparam logic [3:0] IOC_JUMP     = 4'b1011;
    localparam logic [3:0] IOC_IRQ_JUMP = 4'b1001;

    typedef enum logic [2:0] {
        SKC_NEVER    = 3'd0,
        SKC_NEG      = 3'd1,
        SKC_CARRY    = 3'd2,
        SKC_POS      = 3'd3,
        SKC_NOVF     = 3'd4,
        SKC_NOVF_NEG = 3'd5,
        SKC_NOVF_POS = 3'd6,
        SKC_ALWAYS   = 3'd7
    } skip_code_e;

    typedef enum logic [1:0] {
        FLOW_STEP = 2'd0,
        FLOW_SKIP = 2'd1,
        FLOW_JUMP = 2'd2
    } flow_e;

    typedef struct packed {
        skip_code_e skip;
        logic       jump_req;
        logic       irq_jump_req;
    } ctl_fields_t;

    typedef struct packed {
        logic neg;
        logic carry;
        logic ovf;
        logic zero;
    } alu_flags_t;

    function automatic ctl_fields_t split_instr(input logic [INSTR_W-1:0] w);
        ctl_fields_t f;
        logic        in_grp;
        in_grp         = (w[GRP_HI:GRP_LO] == IO_GROUP_SEL);
        f.skip         = skip_code_e'(w[SKIP_HI:SKIP_LO]);
        f.jump_req     = in_grp && (w[IOC_HI:IOC_LO] == IOC_JUMP);
        f.irq_jump_req = in_grp && (w[IOC_HI:IOC_LO] == IOC_IRQ_JUMP);
        return f;
    endfunction

    function automatic logic is_positive(input alu_flags_t fl);
        return !fl.neg && !fl.zero;
    endfunction

endpackage

// File: rtl/useq_cond_eval.sv
module useq_cond_eval
    import useq_pkg::*;
(
    input  skip_code_e code,
    input  alu_flags_t flags,
    output logic       hit
);
    logic pos;
    logic novf;

    always_comb begin
        pos  = is_positive(flags);
        novf = !flags.ovf;
        unique case (code)
            SKC_NEVER:    hit = 1'b0;
            SKC_NEG:      hit = flags.neg;
            SKC_CARRY:    hit = flags.carry;
            SKC_POS:      hit = pos;
            SKC_NOVF:     hit = novf;
            SKC_NOVF_NEG: hit = novf || flags.neg;
            SKC_NOVF_POS: hit = novf || pos;
            SKC_ALWAYS:   hit = 1'b1;
            default:      hit = 1'b0;
        endcase
    end

    always_comb begin
        if (flags.zero) begin
            AST_ZERO_NOT_POS: assert (!(code == SKC_POS && hit)); // R4
        end
    end
endmodule

// File: rtl/useq_irq_latch.sv
module useq_irq_latch (
    input  logic clk,
    input  logic rst,
    input  logic irq_req,
    input  logic consume,
    output logic pending
);
    logic req_q;
    logic rise;

    assign rise = irq_req && !req_q;

    always_ff @(posedge clk) begin
        req_q <= irq_req;
        if (rst) begin
            pending <= 1'b0;
        end else if (rise) begin
            pending <= 1'b1;
        end else if (consume) begin
            pending <= 1'b0;
        end
    end

    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_req) |=> pending); // R7
    AST_CONSUME_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (consume && !$rose(irq_req)) |=> !pending); // R6
    AST_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (pending && !consume) |=> pending); // R7
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> !pending); // R1
endmodule

// File: rtl/useq_next_pc.sv
module useq_next_pc
    import useq_pkg::*;
#(
    parameter int PC_W = 10
) (
    input  logic [PC_W-1:0] pc,
    input  ctl_fields_t     ctl,
    input  logic            skip_hit,
    input  logic            irq_pending,
    input  logic [PC_W-1:0] target,
    output logic [PC_W-1:0] pc_next,
    output logic            irq_consume,
    output flow_e           flow
);
    localparam logic [PC_W-1:0] STEP_ONE = PC_W'(1);
    localparam logic [PC_W-1:0] STEP_TWO = PC_W'(2);

    logic take_irq;

    always_comb begin
        take_irq    = ctl.irq_jump_req && irq_pending;
        irq_consume = take_irq;
        if (ctl.jump_req || take_irq) begin
            flow = FLOW_JUMP;
        end else if (skip_hit) begin
            flow = FLOW_SKIP;
        end else begin
            flow = FLOW_STEP;
        end
        unique case (flow)
            FLOW_JUMP: pc_next = target;
            FLOW_SKIP: pc_next = pc + STEP_TWO;
            default:   pc_next = pc + STEP_ONE;
        endcase
    end

    always_comb begin
        if (ctl.jump_req) begin
            AST_JUMP_WINS: assert (flow == FLOW_JUMP); // R8
        end
    end
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
    import useq_pkg::*;
#(
    parameter int PC_W   = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [INSTR_W-1:0] instr,
    input  logic              flag_neg,
    input  logic              flag_carry,
    input  logic              flag_ovf,
    input  logic [DATA_W-1:0] alu_result,
    input  logic              irq_req,
    output logic [PC_W-1:0]   rom_addr
);
    localparam logic [PC_W-1:0] PC_RESET = '0;

    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] pc_d;
    ctl_fields_t     ctl;
    alu_flags_t      flags;
    logic            skip_hit;
    logic            irq_pending;
    logic            irq_consume;
    flow_e           flow;

    always_comb begin
        ctl         = split_instr(instr);
        flags.neg   = flag_neg;
        flags.carry = flag_carry;
        flags.ovf   = flag_ovf;
        flags.zero  = (alu_result == '0);
    end

    useq_cond_eval u_cond (
        .code  (ctl.skip),
        .flags (flags),
        .hit   (skip_hit)
    );

    useq_irq_latch u_irq (
        .clk     (clk),
        .rst     (rst),
        .irq_req (irq_req),
        .consume (irq_consume),
        .pending (irq_pending)
    );

    useq_next_pc #(.PC_W(PC_W)) u_next (
        .pc          (pc_q),
        .ctl         (ctl),
        .skip_hit    (skip_hit),
        .irq_pending (irq_pending),
        .target      (alu_result[PC_W-1:0]),
        .pc_next     (pc_d),
        .irq_consume (irq_consume),
        .flow        (flow)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= PC_RESET;
        end else begin
            pc_q <= pc_d;
        end
    end

    assign rom_addr = pc_q;

    AST_RESET_PC: assert property (@(posedge clk)
        rst |=> (rom_addr == '0)); // R1
    AST_PLAIN_STEP: assert property (@(posedge clk) disable iff (rst)
        (flow == FLOW_STEP) |=> (rom_addr == PC_W'($past(rom_addr) + 1))); // R2
    AST_SKIP_TWO: assert property (@(posedge clk) disable iff (rst)
        (flow == FLOW_SKIP) |=> (rom_addr == PC_W'($past(rom_addr) + 2))); // R3
    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
        (flow == FLOW_JUMP) |=> (rom_addr == $past(alu_result[PC_W-1:0]))); // R5
    AST_ALWAYS_SKIPS: assert property (@(posedge clk) disable iff (rst)
        (ctl.skip == SKC_ALWAYS && flow != FLOW_JUMP) |-> (flow == FLOW_SKIP)); // R3
    AST_NO_STRAY_JUMP: assert property (@(posedge clk) disable iff (rst)
        (instr[GRP_HI:GRP_LO] != IO_GROUP_SEL) |-> (flow != FLOW_JUMP)); // R9
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        (ctl.irq_jump_req && !ctl.jump_req && !irq_pending) |-> (flow != FLOW_JUMP)); // R6
endmodule

// File: tb/sim_useq_sequencer.sv
module sim_useq_sequencer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr = '0;
    logic        flag_neg = 1'b0, flag_carry = 1'b0, flag_ovf = 1'b0;
    logic [15:0] alu_result = '0;
    logic        irq_req = 1'b0;
    logic [9:0]  rom_addr;

    int n_chk = 0;
    int n_bad = 0;

    // reference model state
    int    m_pc = 0;
    bit    m_pend = 0;
    bit    m_prev = 0;
    string last_tag = "R1";

    always #2.5 clk = ~clk;

    useq_sequencer u0 (
        .clk(clk), .rst(rst), .instr(instr),
        .flag_neg(flag_neg), .flag_carry(flag_carry), .flag_ovf(flag_ovf),
        .alu_result(alu_result), .irq_req(irq_req), .rom_addr(rom_addr)
    );

    function automatic logic [31:0] mk(input int skip, input int grp, input int code);
        logic [31:0] w;
        w = $urandom;
        w[15:13] = skip[2:0];
        w[25:24] = grp[1:0];
        w[11:8]  = code[3:0];
        return w;
    endfunction

    function automatic bit cond(input int code, input bit n, input bit c, input bit v, input int res);
        bit pos;
        pos = !n && (res != 0);
        case (code)
            0: return 0;
            1: return n;
            2: return c;
            3: return pos;
            4: return !v;
            5: return !v || n;
            6: return !v || pos;
            default: return 1;
        endcase
    endfunction

    task automatic step(input logic [31:0] w, input bit n, input bit c, input bit v,
                        input int res, input bit irq, input bit r, input string tag);
        int  nxt;
        bit  rise, jmp, jmpi_take, skip_req;
        @(negedge clk);
        n_chk++;
        if (rom_addr !== m_pc[9:0]) begin
            n_bad++;
            $display("FAIL %s: rom_addr=%0d expected=%0d", last_tag, rom_addr, m_pc);
        end
        instr = w; flag_neg = n; flag_carry = c; flag_ovf = v;
        alu_result = res[15:0]; irq_req = irq; rst = r;
        if (r) begin
            nxt = 0; m_pend = 0;
        end else begin
            rise      = irq && !m_prev;
            jmp       = (w[25:24] == 2'b01) && (w[11:8] == 4'b1011);
            jmpi_take = (w[25:24] == 2'b01) && (w[11:8] == 4'b1001) && m_pend;
            skip_req  = cond(int'(w[15:13]), n, c, v, res & 16'hFFFF);
            if (jmp || jmpi_take) nxt = res & 10'h3FF;
            else if (skip_req)    nxt = (m_pc + 2) % 1024;
            else                  nxt = (m_pc + 1) % 1024;
            if (rise) m_pend = 1;
            else if (jmpi_take) m_pend = 0;
        end
        m_prev = irq;
        last_tag = tag;
        @(posedge clk);
        m_pc = nxt;
    endtask

    task automatic plain(input string tag, input bit irq = 0);
        step(mk(0, 0, 0), 0, 0, 0, 5, irq, 0, tag);
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: reset with request held high
        for (int i = 0; i < 3; i++) step(mk(7, 1, 11), 1, 1, 1, 77, 1, 1, "R1");
        // R1: held level across reset is not an edge; JMPI not taken
        step(mk(0, 1, 9), 0, 0, 0, 300, 1, 0, "R1");
        // R2: plain stepping
        for (int i = 0; i < 5; i++) plain("R2");
        // R3/R4: every skip code against every flag combination
        for (int code = 0; code < 8; code++)
            for (int f = 0; f < 16; f++)
                step(mk(code, 0, 0), f[0], f[1], f[2], f[3] ? 0 : 40, 0, 0,
                     (code == 3 || code == 6) ? "R4" : "R3");
        // R4: zero result, non-negative, is not positive
        step(mk(3, 0, 0), 0, 1, 1, 0, 0, 0, "R4");
        step(mk(3, 0, 0), 0, 0, 0, 16'h8000, 0, 0, "R4");
        // R5 then R2 wrap
        step(mk(0, 1, 11), 1, 0, 0, 16'hFFFF, 0, 0, "R5");
        plain("R2");
        plain("R2");
        step(mk(0, 1, 11), 0, 0, 0, 16'h0BFE, 0, 0, "R5");
        step(mk(7, 0, 0), 0, 0, 0, 3, 0, 0, "R3");
        // R8: jump beats skip-always
        step(mk(7, 1, 11), 1, 1, 0, 123, 0, 0, "R8");
        // R8/R6: untaken JMPI leaves skip in effect
        step(mk(7, 1, 9), 0, 0, 0, 500, 0, 0, "R8");
        // R9: codes outside group 01
        step(mk(0, 0, 11), 0, 0, 0, 600, 0, 0, "R9");
        step(mk(0, 2, 11), 0, 0, 0, 600, 0, 0, "R9");
        step(mk(0, 3, 9),  0, 0, 0, 600, 1, 0, "R9");
        // R7: edge latched above; held level; JMPI consumes
        plain("R7", 1);
        step(mk(7, 1, 9), 0, 0, 0, 222, 1, 0, "R6");
        step(mk(0, 1, 9), 0, 0, 0, 333, 1, 0, "R7");
        plain("R7", 1);
        plain("R7", 0);
        step(mk(0, 1, 9), 0, 0, 0, 444, 0, 0, "R7");
        // R10: new edge in the clock of a taken JMPI
        plain("R10", 1);
        plain("R10", 0);
        step(mk(0, 1, 9), 0, 0, 0, 111, 1, 0, "R10");
        step(mk(0, 1, 9), 0, 0, 0, 888, 1, 0, "R10");
        step(mk(0, 1, 9), 0, 0, 0, 999, 1, 0, "R10");
        // R1: reset clears pending
        plain("R1", 0);
        plain("R1", 1);
        step(mk(0, 0, 0), 0, 0, 0, 0, 0, 1, "R1");
        step(mk(0, 1, 9), 0, 0, 0, 700, 0, 0, "R1");
        // mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            int sel, grp, code;
            sel  = $urandom_range(0, 9);
            grp  = (sel < 6) ? 1 : $urandom_range(0, 3);
            code = (sel < 3) ? 9 : (sel < 5) ? 11 : $urandom_range(0, 15);
            step(mk($urandom_range(0, 7), grp, code), $urandom_range(0, 1),
                 $urandom_range(0, 1), $urandom_range(0, 1),
                 ($urandom_range(0, 5) == 0) ? 0 : $urandom_range(0, 65535),
                 $urandom_range(0, 3) == 0, $urandom_range(0, 199) == 0, "R8");
        end
        plain("R2");
        @(negedge clk);
        n_chk++;
        if (rom_addr !== m_pc[9:0]) begin
            n_bad++;
            $display("FAIL %s: rom_addr=%0d expected=%0d", last_tag, rom_addr, m_pc);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule